// File: doc/BRIEF.md
# Split Decade Counter With Set-to-Nine

A four-bit counter built from two sections that share one system clock but count on separate strobes. A divide-by-2 section drives output bit 0 (QA). A divide-by-5 section drives bits 3..1 (QD QC QB). Each section steps when its own count strobe shows a falling edge, and that edge is found by comparing the strobe with its value at the previous clock edge.

The two sections can run alone. They can also be chained: wiring QA back to the divide-by-5 strobe gives a BCD decade count, and the opposite chaining gives a divide-by-10 output. A two-input clear zeroes every bit. A two-input preset loads the value nine (1001). The preset wins over the clear, and both block counting while they are active.

Top module: `split_decade_ctr`

## Requirements
- R1: After the asynchronous reset `rst_ni` is low, `q_o` reads 0. A strobe that stays low after reset does not count as a falling edge.
- R2: At a clock edge where `cnt_a_i` is sampled 0, and was sampled 1 at the edge before, QA (`q_o[0]`) toggles. No clear or preset may be active.
- R3: Each such falling edge of `cnt_b_i` steps `q_o[3:1]` through 0,1,2,3,4 and then back to 0. The field never holds a value above 4.
- R4: The two sections are independent. Falling edges of `cnt_a_i` never change `q_o[3:1]`, and falling edges of `cnt_b_i` never change `q_o[0]`.
- R5: When `clr_a_i` and `clr_b_i` are both 1, and the preset is not active, `q_o` becomes 0 at the next clock edge. With only one of the two at 1, nothing changes.
- R6: When `nine_a_i` and `nine_b_i` are both 1, `q_o` becomes 4'b1001 at the next clock edge. With only one of the two at 1, nothing changes.
- R7: When the preset and the clear are both active, the preset wins and `q_o` is 4'b1001.
- R8: A falling edge that occurs while the clear or the preset is active is discarded. It does not step any section after the control is released.
- R9: With `q_o[0]` fed back to `cnt_b_i` and pulses applied on `cnt_a_i`, `q_o` counts 0 through 9 in BCD and then returns to 0.
- R10: Without a falling edge, clear or preset, `q_o` holds its value. This applies whether a strobe is held high or held low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cnt_a_i | input | 1 | Count strobe of the divide-by-2 section |
| cnt_b_i | input | 1 | Count strobe of the divide-by-5 section |
| clr_a_i | input | 1 | Clear input, first of two |
| clr_b_i | input | 1 | Clear input, second of two |
| nine_a_i | input | 1 | Preset-to-nine input, first of two |
| nine_b_i | input | 1 | Preset-to-nine input, second of two |
| q_o | output | 4 | Count value: bit 0 is QA, bits 3..1 are QD QC QB |

## Verification
Every result is due at the first clock edge after its cause. A falling edge shows up at the edge where the strobe is first seen low, and a clear or preset shows up at the edge where it is first seen active. In chained mode the divide-by-5 section therefore steps one edge after QA falls. The bench drives inputs on the falling clock edge and updates its arithmetic model at the rising edge. It compares `q_o` at the next falling edge, so every check sits exactly one register behind its stimulus.

// File: rtl/sdc_pkg.sv
package sdc_pkg;
  typedef enum logic [1:0] {
    ACT_HOLD  = 2'd0,
    ACT_STEP  = 2'd1,
    ACT_CLEAR = 2'd2,
    ACT_NINE  = 2'd3
  } act_e;

  // preset > clear > count
  function automatic act_e pick_act(input logic nine, input logic clr, input logic fall);
    if (nine)      return ACT_NINE;
    else if (clr)  return ACT_CLEAR;
    else if (fall) return ACT_STEP;
    else           return ACT_HOLD;
  endfunction
endpackage

// File: rtl/fall_detect.sv
module fall_detect #(
  parameter int N = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] strobe_i,
  output logic [N-1:0] fall_o
);
  logic [N-1:0] prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '0;
    else         prev_q <= strobe_i;
  end

  assign fall_o = prev_q & ~strobe_i;
endmodule

// File: rtl/mod_counter.sv
module mod_counter
  import sdc_pkg::*;
#(
  parameter int MOD      = 5,
  parameter int W        = (MOD > 1) ? $clog2(MOD) : 1,
  parameter int NINE_VAL = MOD - 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  act_e         act_i,
  output logic [W-1:0] q_o
);
  localparam logic [W-1:0] LAST = W'(MOD - 1);
  localparam logic [W-1:0] NINE = W'(NINE_VAL);

  logic [W-1:0] q_q, q_d;

  always_comb begin
    unique case (act_i)
      ACT_NINE:  q_d = NINE;
      ACT_CLEAR: q_d = '0;
      ACT_STEP:  q_d = (q_q == LAST) ? '0 : q_q + 1'b1;
      default:   q_d = q_q;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_q <= '0;
    else         q_q <= q_d;
  end

  assign q_o = q_q;
endmodule

// File: rtl/split_decade_ctr.sv
module split_decade_ctr
  import sdc_pkg::*;
#(
  parameter int LO_MOD = 2,
  parameter int HI_MOD = 5,
  localparam int LO_W  = $clog2(LO_MOD),
  localparam int HI_W  = $clog2(HI_MOD),
  localparam int QW    = LO_W + HI_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cnt_a_i,
  input  logic          cnt_b_i,
  input  logic          clr_a_i,
  input  logic          clr_b_i,
  input  logic          nine_a_i,
  input  logic          nine_b_i,
  output logic [QW-1:0] q_o
);
  logic [1:0] fall;
  logic       clr_all, nine_all;
  act_e       act_lo, act_hi;

  fall_detect #(.N(2)) u_fall (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .strobe_i ({cnt_b_i, cnt_a_i}),
    .fall_o   (fall)
  );

  assign clr_all  = clr_a_i & clr_b_i;
  assign nine_all = nine_a_i & nine_b_i;
  assign act_lo   = pick_act(nine_all, clr_all, fall[0]);
  assign act_hi   = pick_act(nine_all, clr_all, fall[1]);

  // nine = top of each section: 1 + 2*4
  mod_counter #(.MOD(LO_MOD), .W(LO_W), .NINE_VAL(LO_MOD - 1)) u_lo (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .act_i  (act_lo),
    .q_o    (q_o[LO_W-1:0])
  );

  mod_counter #(.MOD(HI_MOD), .W(HI_W), .NINE_VAL(HI_MOD - 1)) u_hi (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .act_i  (act_hi),
    .q_o    (q_o[QW-1:LO_W])
  );
endmodule

// File: rtl/sdc_checker.sv
module sdc_checker (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       cnt_a_i,
  input logic       cnt_b_i,
  input logic       clr_a_i,
  input logic       clr_b_i,
  input logic       nine_a_i,
  input logic       nine_b_i,
  input logic [3:0] q_o
);
  logic pa, pb;
  logic frc, fa, fb;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pa <= 1'b0;
      pb <= 1'b0;
    end else begin
      pa <= cnt_a_i;
      pb <= cnt_b_i;
    end
  end

  assign frc = (clr_a_i & clr_b_i) | (nine_a_i & nine_b_i);
  assign fa  = pa & ~cnt_a_i;
  assign fb  = pb & ~cnt_b_i;

  AST_NINE_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (nine_a_i && nine_b_i) |=> (q_o == 4'b1001)); // R6
  AST_CLEAR_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_a_i && clr_b_i && !(nine_a_i && nine_b_i)) |=> (q_o == 4'b0000)); // R5
  AST_DIV5_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    q_o[3:1] <= 3'd4); // R3
  AST_QA_TOGGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fa && !frc) |=> (q_o[0] != $past(q_o[0]))); // R2
  AST_QA_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!fa && !frc) |=> $stable(q_o[0])); // R10
  AST_HI_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!fb && !frc) |=> $stable(q_o[3:1])); // R4
endmodule

bind split_decade_ctr sdc_checker u_sdc_checker (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .cnt_a_i  (cnt_a_i),
  .cnt_b_i  (cnt_b_i),
  .clr_a_i  (clr_a_i),
  .clr_b_i  (clr_b_i),
  .nine_a_i (nine_a_i),
  .nine_b_i (nine_b_i),
  .q_o      (q_o)
);

// File: tb/sim_split_decade_ctr.sv
`timescale 1ns/1ps
module sim_split_decade_ctr;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       a = 1'b0, b_drv = 1'b0, chain = 1'b0;
  logic       ca = 1'b0, cb = 1'b0, na = 1'b0, nb = 1'b0;
  logic       b;
  logic [3:0] q;

  int vectors = 0, errors = 0;
  int m_a = 0, m_b = 0;
  logic pa = 1'b0, pb = 1'b0;
  logic [15:0] lfsr = 16'hACE1;

  always #5 clk = ~clk;

  assign b = chain ? q[0] : b_drv;

  split_decade_ctr u0 (
    .clk_i(clk), .rst_ni(rst_n), .cnt_a_i(a), .cnt_b_i(b),
    .clr_a_i(ca), .clr_b_i(cb), .nine_a_i(na), .nine_b_i(nb), .q_o(q)
  );

  function automatic logic [3:0] expv();
    return {m_b[2:0], m_a[0]};
  endfunction

  task automatic check(input string tag, input logic [3:0] exp);
    vectors++;
    if (q !== exp) begin
      errors++;
      $display("FAIL %s: q_o=%b expected %b", tag, q, exp);
    end
  endtask

  // starts and ends at negedge
  task automatic cyc(input logic ia, input logic ib, input logic ica, input logic icb,
                     input logic ina, input logic inb, input string tag);
    logic be, fa, fb;
    a = ia; b_drv = ib; ca = ica; cb = icb; na = ina; nb = inb;
    @(posedge clk);
    be = chain ? logic'(m_a[0]) : ib;
    fa = pa & ~ia;
    fb = pb & ~be;
    if (ina && inb) begin
      m_a = 1; m_b = 4;
    end else if (ica && icb) begin
      m_a = 0; m_b = 0;
    end else begin
      if (fa) m_a = 1 - m_a;
      if (fb) m_b = (m_b == 4) ? 0 : m_b + 1;
    end
    pa = ia; pb = be;
    @(negedge clk);
    check(tag, expv());
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog: q_o=%b expected completion", q);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    #1;
    check("R1 reset", 4'b0000);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    cyc(0, 0, 0, 0, 0, 0, "R1 low strobe after reset");
    // divide-by-2 alone, b held high
    for (int i = 0; i < 8; i++) begin
      cyc(1, 1, 0, 0, 0, 0, "R10 a high");
      cyc(0, 1, 0, 0, 0, 0, "R2 R4 a fall");
    end
    // divide-by-5 alone, a held low
    for (int i = 0; i < 12; i++) begin
      cyc(0, 1, 0, 0, 0, 0, "R10 b high");
      cyc(0, 0, 0, 0, 0, 0, "R3 R4 b fall");
    end
    // single-input controls ignored
    cyc(1, 1, 1, 0, 0, 0, "R5 one clear");
    cyc(1, 1, 0, 1, 0, 0, "R5 one clear");
    cyc(1, 1, 0, 0, 1, 0, "R6 one nine");
    cyc(1, 1, 0, 0, 0, 1, "R6 one nine");
    cyc(1, 1, 0, 0, 1, 1, "R6 nine");
    cyc(1, 1, 1, 1, 0, 0, "R5 clear");
    cyc(1, 1, 1, 1, 1, 1, "R7 nine over clear");
    // falls during force are lost
    cyc(0, 0, 1, 1, 0, 0, "R8 fall under clear");
    cyc(0, 0, 0, 0, 0, 0, "R8 no late step");
    check("R8 still zero", 4'b0000);
    cyc(1, 1, 0, 0, 0, 0, "R10");
    cyc(0, 0, 0, 0, 1, 1, "R8 fall under nine");
    cyc(0, 0, 0, 0, 0, 0, "R8 no late step");
    check("R8 still nine", 4'b1001);
    // BCD chain
    cyc(0, 0, 1, 1, 0, 0, "R5 clear");
    chain = 1'b1;
    cyc(0, 0, 0, 0, 0, 0, "R9 settle");
    for (int i = 1; i <= 25; i++) begin
      cyc(1, 0, 0, 0, 0, 0, "R9 high");
      cyc(0, 0, 0, 0, 0, 0, "R9 fall");
      cyc(0, 0, 0, 0, 0, 0, "R9 carry");
      if (q !== 4'(i % 10)) begin
        errors++;
        $display("FAIL R9 bcd: q_o=%b expected %b", q, 4'(i % 10));
      end
      vectors++;
    end
    chain = 1'b0;
    // pseudo-random sweep
    for (int i = 0; i < 4000; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      cyc(lfsr[0], lfsr[1], lfsr[2] & lfsr[5], lfsr[3] & lfsr[6],
          lfsr[4] & lfsr[7] & lfsr[8], lfsr[9] & lfsr[11] & lfsr[12], "R2 R3 R5 R6 R7 R8 R10 sweep");
    end
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule